// File: doc/BRIEF.md
# Serial Port Host Register Interface and Setup Sequencer

This block sits between a host processor bus and a serial transmit/receive engine. It turns the host's chip select, control/data select and active-low read and write strobes into one of four accesses: a write to the control register, a read of the status word, a write of the transmit data byte and a read of the received data byte. The control register and the status word share one address, and so do the two data buffers.

Control writes follow a fixed setup order. The first control write after a reset is a mode word. It sets the bit-rate clock divider, the character length, parity and the stop-bit setting. Every later control write is a command word. Command words switch the transmitter and receiver on or off and can ask for the error flags to be cleared. A command can also perform an internal reset, which returns the block to waiting for a mode word. The serial engines are outside this block. They appear only as flag and data inputs, and they read the decoded settings from the outputs.

Top module: `usart_ctrl_regs`

## Requirements
- R1: While `cs_n` is high, no access takes place. Settings, command outputs and `rdata` keep their values, and neither `tx_load` nor `rx_take` pulses.
- R2: A write with `cs_n`=0, `cd`=1, `wr_n`=0 and `rd_n`=1 targets the control register. A read with `cs_n`=0, `cd`=1, `rd_n`=0 and `wr_n`=1 returns the status word on `rdata` from the following clock edge.
- R3: A data write (`cd`=0) loads `tx_data` and pulses `tx_load` for one cycle. A data read (`cd`=0) puts `rx_data` on `rdata` and pulses `rx_take` for one cycle.
- R4: After `rst`, `mode_wait` is 1. The first control write is taken as the mode word and clears `mode_wait`.
- R5: A control write made while `mode_wait` is 0 is a command word and leaves the mode settings unchanged. Command bit 0 drives `tx_en`, bit 2 drives `rx_en`, and bit 4 pulses `err_clr` for one cycle.
- R6: A command word with bit 6 set clears `tx_en` and `rx_en` and sets `mode_wait`. The next control write is then taken as a new mode word.
- R7: Mode bits 1:0 set `baud_div`: 01 gives 1, 10 gives 16, 11 gives 64, and 00 falls back to 1.
- R8: Mode bits 3:2 set `char_bits`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R9: Mode bit 4 drives `par_en`. Mode bit 5 drives `par_even`, where 1 means even parity and 0 means odd parity.
- R10: Mode bits 7:6 appear unchanged on `stop_sel`, where 11 means two stop bits.
- R11: The status word is laid out as follows: bit 0 is transmitter ready, bit 1 is receive data available, bit 2 is transmitter empty, bit 3 is parity error, bit 4 is overrun error and bit 5 is framing error. Bits 7:6 read as 0.
- R12: A cycle with both `rd_n` and `wr_n` low is not an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| tx_ready | input | 1 | Transmit buffer can take a byte |
| tx_empty | input | 1 | Transmit shift register is empty |
| rx_avail | input | 1 | A received byte is waiting |
| par_err | input | 1 | Parity error flag |
| ovr_err | input | 1 | Overrun error flag |
| frm_err | input | 1 | Framing error flag |
| rx_data | input | 8 | Received byte from the receive engine |
| tx_data | output | 8 | Byte to transmit |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is loaded |
| rx_take | output | 1 | One-cycle pulse when the host reads the received byte |
| baud_div | output | 7 | Clock-to-bit-rate divider (1, 16 or 64) |
| char_bits | output | 4 | Character length in bits (5 to 8) |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| stop_sel | output | 2 | Stop-bit code |
| tx_en | output | 1 | Transmitter enabled |
| rx_en | output | 1 | Receiver enabled |
| err_clr | output | 1 | One-cycle pulse to clear the error flags |
| mode_wait | output | 1 | 1 while the next control write will be a mode word |

## Verification
The assertions assume the host presents each access for exactly one clock cycle. A strobe held low for several cycles would be counted as several accesses, which matters for the sequencer because a second control write counts as a command. The bench drives every access on a falling edge and returns `cs_n`, `rd_n` and `wr_n` to idle on the next falling edge. The serial-engine flag inputs change only between accesses, so any status read samples stable values.

// File: rtl/usart_ctrl_pkg.sv
package usart_ctrl_pkg;
  localparam int CW = 8;          // control / status word width
  localparam int BDW = 7;         // baud divider output width
  localparam int CLW = 4;         // character length output width

  typedef struct packed {
    logic [BDW-1:0] baud_div;
    logic [CLW-1:0] char_bits;
    logic           par_en;
    logic           par_even;
    logic [1:0]     stop_sel;
  } mode_cfg_t;

  localparam mode_cfg_t MODE_RST = '{baud_div: BDW'(1), char_bits: CLW'(5),
                                     par_en: 1'b0, par_even: 1'b0, stop_sel: 2'b00};

  function automatic mode_cfg_t decode_mode(input logic [CW-1:0] w);
    mode_cfg_t m;
    case (w[1:0])
      2'b10:   m.baud_div = BDW'(16);
      2'b11:   m.baud_div = BDW'(64);
      default: m.baud_div = BDW'(1);
    endcase
    m.char_bits = CLW'(5) + CLW'(w[3:2]);
    m.par_en    = w[4];
    m.par_even  = w[5];
    m.stop_sel  = w[7:6];
    return m;
  endfunction
endpackage

// File: rtl/usart_bus_decode.sv
module usart_bus_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic cd,
  input  logic rd_n,
  input  logic wr_n,
  output logic ctl_wr,
  output logic stat_rd,
  output logic dat_wr,
  output logic dat_rd
);
  logic sel_wr, sel_rd;

  // exactly one strobe active with chip selected
  assign sel_wr = !cs_n && !wr_n && rd_n;
  assign sel_rd = !cs_n && !rd_n && wr_n;

  assign ctl_wr  = sel_wr && cd;
  assign stat_rd = sel_rd && cd;
  assign dat_wr  = sel_wr && !cd;
  assign dat_rd  = sel_rd && !cd;

  // R12
  access_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_wr, stat_rd, dat_wr, dat_rd}));
  // R1
  deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !(ctl_wr || stat_rd || dat_wr || dat_rd));
endmodule

// File: rtl/usart_init_seq.sv
module usart_init_seq
  import usart_ctrl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [CW-1:0] wdata,
  output mode_cfg_t     mode_q,
  output logic          tx_en,
  output logic          rx_en,
  output logic          err_clr,
  output logic          mode_wait
);
  localparam int TXEN_BIT = 0;
  localparam int RXEN_BIT = 2;
  localparam int ECLR_BIT = 4;
  localparam int IRST_BIT = 6;

  typedef enum logic {ST_MODE, ST_CMD} seq_t;
  seq_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_MODE;
      mode_q  <= MODE_RST;
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      err_clr <= 1'b0;
    end else begin
      err_clr <= 1'b0;
      if (ctl_wr) begin
        if (st == ST_MODE) begin
          mode_q <= decode_mode(wdata);
          st     <= ST_CMD;
        end else if (wdata[IRST_BIT]) begin
          tx_en <= 1'b0;
          rx_en <= 1'b0;
          st    <= ST_MODE;
        end else begin
          tx_en   <= wdata[TXEN_BIT];
          rx_en   <= wdata[RXEN_BIT];
          err_clr <= wdata[ECLR_BIT];
        end
      end
    end
  end

  assign mode_wait = (st == ST_MODE);

  // R4
  mode_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && mode_wait) |=> !mode_wait);
  // R6
  irst_back_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !mode_wait && wdata[IRST_BIT]) |=> (mode_wait && !tx_en && !rx_en));
  // R5
  mode_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_wait |=> $stable(mode_q));
  // R5
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> !err_clr);
endmodule

// File: rtl/usart_data_path.sv
module usart_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status_w,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_load,
  output logic              rx_take
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      tx_data <= '0;
      tx_load <= 1'b0;
      rx_take <= 1'b0;
    end else begin
      tx_load <= dat_wr;
      rx_take <= dat_rd;
      if (dat_wr) tx_data <= wdata;
      if (stat_rd)     rdata <= status_w;
      else if (dat_rd) rdata <= rx_data;
    end
  end

  // R3
  tx_capture_chk: assert property (@(posedge clk) disable iff (rst)
    dat_wr |=> (tx_load && tx_data == $past(wdata)));
  // R3
  rx_return_chk: assert property (@(posedge clk) disable iff (rst)
    dat_rd |=> (rx_take && rdata == $past(rx_data)));
  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(stat_rd || dat_rd) |=> $stable(rdata));
endmodule

// File: rtl/usart_ctrl_regs.sv
module usart_ctrl_regs
  import usart_ctrl_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           cd,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  input  logic           tx_ready,
  input  logic           tx_empty,
  input  logic           rx_avail,
  input  logic           par_err,
  input  logic           ovr_err,
  input  logic           frm_err,
  input  logic [CW-1:0]  rx_data,
  output logic [CW-1:0]  tx_data,
  output logic           tx_load,
  output logic           rx_take,
  output logic [BDW-1:0] baud_div,
  output logic [CLW-1:0] char_bits,
  output logic           par_en,
  output logic           par_even,
  output logic [1:0]     stop_sel,
  output logic           tx_en,
  output logic           rx_en,
  output logic           err_clr,
  output logic           mode_wait
);
  logic ctl_wr, stat_rd, dat_wr, dat_rd;
  mode_cfg_t mode_q;
  logic [CW-1:0] status_w;

  usart_bus_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .ctl_wr(ctl_wr), .stat_rd(stat_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
  );

  usart_init_seq u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .wdata(wdata), .mode_q(mode_q),
    .tx_en(tx_en), .rx_en(rx_en), .err_clr(err_clr), .mode_wait(mode_wait)
  );

  assign status_w = {2'b00, frm_err, ovr_err, par_err, tx_empty, rx_avail, tx_ready};

  usart_data_path #(.DATA_W(CW)) u_dp (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .wdata(wdata), .status_w(status_w), .rx_data(rx_data), .rdata(rdata),
    .tx_data(tx_data), .tx_load(tx_load), .rx_take(rx_take)
  );

  assign baud_div  = mode_q.baud_div;
  assign char_bits = mode_q.char_bits;
  assign par_en    = mode_q.par_en;
  assign par_even  = mode_q.par_even;
  assign stop_sel  = mode_q.stop_sel;

  // R1
  no_strobe_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !(tx_load || rx_take || err_clr));
  // R11
  status_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (rdata[7:6] == 2'b00 && rdata[0] == $past(tx_ready)));
endmodule

// File: tb/usart_ctrl_regs_tb.sv
module usart_ctrl_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, cd = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] wdata = '0, rx_data = '0;
  logic tx_ready = 0, tx_empty = 0, rx_avail = 0, par_err = 0, ovr_err = 0, frm_err = 0;
  logic [7:0] rdata, tx_data;
  logic tx_load, rx_take, par_en, par_even, tx_en, rx_en, err_clr, mode_wait;
  logic [6:0] baud_div;
  logic [3:0] char_bits;
  logic [1:0] stop_sel;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  usart_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .rdata(rdata), .tx_ready(tx_ready), .tx_empty(tx_empty),
    .rx_avail(rx_avail), .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err),
    .rx_data(rx_data), .tx_data(tx_data), .tx_load(tx_load), .rx_take(rx_take),
    .baud_div(baud_div), .char_bits(char_bits), .par_en(par_en), .par_even(par_even),
    .stop_sel(stop_sel), .tx_en(tx_en), .rx_en(rx_en), .err_clr(err_clr),
    .mode_wait(mode_wait)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one access, one cycle; outputs are checked at the falling edge that follows
  task automatic access(input logic c_n, input logic c, input logic r_n,
                        input logic w_n, input logic [7:0] d);
    @(negedge clk);
    cs_n = c_n; cd = c; rd_n = r_n; wr_n = w_n; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R4 mode_wait after reset", mode_wait, 1);
    check("R4 tx_en after reset", tx_en, 0);
    check("R3 tx_load idle", tx_load, 0);
  endtask

  task automatic chk_mode(input logic [7:0] w, input int bd, input int cb,
                          input logic pe, input logic pv, input logic [1:0] st);
    check("R7 baud_div", baud_div, bd);
    check("R8 char_bits", char_bits, cb);
    check("R9 par_en", par_en, pe);
    check("R9 par_even", par_even, pv);
    check("R10 stop_sel", stop_sel, st);
  endtask

  task automatic t_modes();
    do_reset();
    access(0, 1, 1, 0, 8'hCA);
    check("R4 mode_wait cleared", mode_wait, 0);
    chk_mode(8'hCA, 16, 7, 0, 0, 2'b11);
    access(0, 1, 1, 0, 8'h40);             // internal reset, R6
    check("R6 back to mode phase", mode_wait, 1);
    access(0, 1, 1, 0, 8'h3F);
    chk_mode(8'h3F, 64, 8, 1, 1, 2'b00);
    access(0, 1, 1, 0, 8'h40);
    access(0, 1, 1, 0, 8'h5D);
    chk_mode(8'h5D, 1, 8, 1, 0, 2'b01);
    access(0, 1, 1, 0, 8'h40);
    access(0, 1, 1, 0, 8'h84);
    chk_mode(8'h84, 1, 6, 0, 0, 2'b10);   // R7 00 falls back to 1
  endtask

  task automatic t_commands();
    do_reset();
    access(0, 1, 1, 0, 8'hCA);
    access(0, 1, 1, 0, 8'h15);
    check("R5 tx_en", tx_en, 1);
    check("R5 rx_en", rx_en, 1);
    check("R5 err_clr pulse", err_clr, 1);
    check("R5 mode unchanged by command", baud_div, 16);
    @(negedge clk);
    check("R5 err_clr one cycle", err_clr, 0);
    access(0, 1, 1, 0, 8'h01);
    check("R5 rx_en off", rx_en, 0);
    check("R5 mode still 7 bits", char_bits, 7);
    access(0, 1, 1, 0, 8'hC5);
    check("R6 tx_en cleared", tx_en, 0);
    check("R6 mode_wait set", mode_wait, 1);
    check("R6 mode kept until rewritten", stop_sel, 2'b11);
  endtask

  task automatic t_status_data();
    do_reset();
    tx_ready = 1; tx_empty = 0; rx_avail = 1; par_err = 0; ovr_err = 1; frm_err = 0;
    access(0, 1, 0, 1, 8'h00);
    check("R11 status layout", rdata, 8'h13);
    check("R2 status read no rx_take", rx_take, 0);
    tx_ready = 0; tx_empty = 1; rx_avail = 0; par_err = 1; ovr_err = 0; frm_err = 1;
    access(0, 1, 0, 1, 8'h00);
    check("R11 status layout 2", rdata, 8'h2C);
    check("R2 status read no mode change", mode_wait, 1);
    access(0, 0, 1, 0, 8'hA5);
    check("R3 tx_data", tx_data, 8'hA5);
    check("R3 tx_load pulse", tx_load, 1);
    check("R3 data write not control", mode_wait, 1);
    rx_data = 8'h5A;
    access(0, 0, 0, 1, 8'h00);
    check("R3 rx read", rdata, 8'h5A);
    check("R3 rx_take pulse", rx_take, 1);
    @(negedge clk);
    check("R3 rx_take one cycle", rx_take, 0);
  endtask

  task automatic t_ignored();
    do_reset();
    rx_data = 8'h77;
    access(1, 1, 1, 0, 8'hCA);
    check("R1 deselected ctl write", mode_wait, 1);
    access(1, 0, 1, 0, 8'h33);
    check("R1 no tx_load", tx_load, 0);
    check("R1 tx_data kept", tx_data, 8'h00);
    access(1, 0, 0, 1, 8'h00);
    check("R1 no rx_take", rx_take, 0);
    check("R1 rdata kept", rdata, 8'h00);
    access(0, 1, 0, 0, 8'hCA);
    check("R12 both strobes no mode write", mode_wait, 1);
    check("R12 both strobes rdata kept", rdata, 8'h00);
    access(0, 0, 0, 0, 8'h44);
    check("R12 both strobes no tx_load", tx_load, 0);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_commands();
    t_status_data();
    t_ignored();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule